// File: doc/BRIEF.md
# Modified Immediate Constant Expander

The expander turns a 12-bit immediate field from an instruction word into a full 32-bit operand constant. It also produces the carry-out that the shifter would report. A mode input picks one of two encodings. In the wide encoding, an 8-bit value is rotated right by twice a 4-bit count. In the compact encoding, the field either places one byte into a fixed lane pattern, or takes an 8-bit value with its top bit forced to one and rotates it right by a 5-bit count of 8 or more. A right rotation by 8 or more is the same as a left shift by 24 or less.

A decoder feeds the field, the mode and the current carry flag. The block returns the constant, the shifter carry-out and a valid flag. Valid is low for a field that has no legal constant. A parameter selects one of two versions: a registered output with one cycle of latency (the default), or a purely combinational path.

Top module: `immx_expand`

## Requirements
- R1: With `mode_compact`=0, `imm_value` equals `field_in[7:0]` zero-extended to 32 bits and rotated right by 2×`field_in[11:8]` positions.
- R2: With `mode_compact`=0, `carry_out` equals `carry_in` when `field_in[11:8]`=0; otherwise it equals bit 31 of `imm_value`.
- R3: With `mode_compact`=1 and `field_in[11:8]`=4'b0000, `imm_value` is `field_in[7:0]` zero-extended (pattern 000000XY).
- R4: With `mode_compact`=1 and `field_in[11:8]`=4'b0001, the byte sits in bits [7:0] and [23:16], with zeros elsewhere (00XY00XY).
- R5: With `mode_compact`=1 and `field_in[11:8]`=4'b0010, the byte sits in bits [15:8] and [31:24], with zeros elsewhere (XY00XY00).
- R6: With `mode_compact`=1 and `field_in[11:8]`=4'b0011, the byte is copied into all four byte lanes (XYXYXYXY).
- R7: With `mode_compact`=1 and `field_in[11:10]`≠2'b00, `imm_value` is the 8-bit value {1'b1, `field_in[6:0]`} zero-extended and rotated right by `field_in[11:7]` positions.
- R8: With `mode_compact`=1, `carry_out` equals `carry_in` for the lane-pattern forms (R3 to R6) and equals bit 31 of `imm_value` for the rotate form (R7).
- R9: `valid` is low only when `mode_compact`=1, `field_in[11:10]`=2'b00, `field_in[9:8]`≠2'b00 and `field_in[7:0]`=0. It is high for every other input.
- R10: With `REG_OUT`=1, the outputs show the result for the inputs present at the previous rising clock edge. While `rst_n` is low, `imm_value`, `carry_out` and `valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output version |
| rst_n | input | 1 | Active-low synchronous reset |
| field_in | input | 12 | Encoded immediate field |
| mode_compact | input | 1 | 0 selects the wide encoding, 1 selects the compact encoding |
| carry_in | input | 1 | Current carry flag |
| imm_value | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Shifter carry-out |
| valid | output | 1 | High when the field encodes a legal constant |

## Verification
The assertions are sampled on the rising clock edge and check the next-state result computed from the inputs. They therefore assume that `field_in`, `mode_compact` and `carry_in` are stable and known around that edge. The bench changes all inputs only on the falling edge and never drives X or Z. The random stimulus draws full 12-bit fields in both modes, so invalid encodings appear along with legal ones. Directed vectors add the zero-rotate, maximum-rotate and zero-byte pattern cases.

// File: rtl/immx_pkg.sv
package immx_pkg;
    parameter int DATA_W  = 32;
    parameter int BYTE_W  = 8;
    parameter int FIELD_W = 12;

    typedef struct packed {
        logic              valid;
        logic              carry;
        logic [DATA_W-1:0] value;
    } immx_res_t;

    // Rotate right a zero-extended operand by amt positions.
    function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] x,
                                                    input logic [4:0]        amt);
        logic [2*DATA_W-1:0] dbl;
        dbl = {x, x} >> amt;
        return dbl[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/immx_wide_rot.sv
module immx_wide_rot
    import immx_pkg::*;
(
    input  logic [FIELD_W-1:0] field_in,
    input  logic               carry_in,
    output immx_res_t          res_o
);
    localparam int ROTF_W = FIELD_W - BYTE_W;

    logic [ROTF_W-1:0] rot_field;
    logic [4:0]        rot_amt;
    logic [DATA_W-1:0] base;

    always_comb begin
        rot_field   = field_in[FIELD_W-1:BYTE_W];
        rot_amt     = {rot_field, 1'b0};
        base        = {{(DATA_W-BYTE_W){1'b0}}, field_in[BYTE_W-1:0]};
        res_o.value = rot_right(base, rot_amt);
        res_o.carry = (rot_field == '0) ? carry_in : res_o.value[DATA_W-1];
        res_o.valid = 1'b1;
    end
endmodule

// File: rtl/immx_compact.sv
module immx_compact
    import immx_pkg::*;
(
    input  logic [FIELD_W-1:0] field_in,
    input  logic               carry_in,
    output immx_res_t          res_o
);
    localparam int LANES = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] byte_v;
    logic [1:0]        pat_code;
    logic              is_pattern;
    logic [DATA_W-1:0] pat_value;
    logic [DATA_W-1:0] shf_value;
    logic [4:0]        shf_amt;
    logic [LANES-1:0]  lane_en;

    // lane enables per pattern code
    always_comb begin
        unique case (pat_code)
            2'b00:   lane_en = LANES'(1);
            2'b01:   lane_en = LANES'(4'b0101);
            2'b10:   lane_en = LANES'(4'b1010);
            default: lane_en = '1;
        endcase
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign pat_value[l*BYTE_W +: BYTE_W] = lane_en[l] ? byte_v : '0;
        end
    endgenerate

    always_comb begin
        byte_v     = field_in[BYTE_W-1:0];
        pat_code   = field_in[BYTE_W+1:BYTE_W];
        is_pattern = (field_in[FIELD_W-1:FIELD_W-2] == 2'b00);
        shf_amt    = field_in[FIELD_W-1:BYTE_W-1];
        shf_value  = rot_right({{(DATA_W-BYTE_W){1'b0}}, 1'b1, field_in[BYTE_W-2:0]},
                               shf_amt);
        if (is_pattern) begin
            res_o.value = pat_value;
            res_o.carry = carry_in;
            res_o.valid = !((pat_code != 2'b00) && (byte_v == '0));
        end else begin
            res_o.value = shf_value;
            res_o.carry = shf_value[DATA_W-1];
            res_o.valid = 1'b1;
        end
    end
endmodule

// File: rtl/immx_expand.sv
module immx_expand
    import immx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field_in,
    input  logic               mode_compact,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  imm_value,
    output logic               carry_out,
    output logic               valid
);
    immx_res_t wide_res, cmp_res, res_d, res_q;

    immx_wide_rot u_wide (.field_in(field_in), .carry_in(carry_in), .res_o(wide_res));
    immx_compact  u_cmp  (.field_in(field_in), .carry_in(carry_in), .res_o(cmp_res));

    always_comb begin
        res_d = mode_compact ? cmp_res : wide_res;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign imm_value = res_q.value;
    assign carry_out = res_q.carry;
    assign valid     = res_q.valid;

    // Rotation in wide mode keeps the number of set bits.
    assert_wide_popcount_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_compact |-> ($countones(res_d.value) == $countones(field_in[BYTE_W-1:0])));

    assert_wide_carry_norot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_compact && field_in[FIELD_W-1:BYTE_W] == '0) |-> (res_d.carry == carry_in));

    assert_replicate_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_compact && field_in[FIELD_W-1:BYTE_W] == 4'b0011) |->
        (res_d.value[31:24] == res_d.value[7:0] && res_d.value[23:16] == res_d.value[15:8]));

    // Shift form carries exactly one forced bit plus the seven payload bits.
    assert_shift_popcount_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_compact && field_in[FIELD_W-1:FIELD_W-2] != 2'b00) |->
        ($countones(res_d.value) == 1 + $countones(field_in[BYTE_W-2:0])));

    assert_pattern_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_compact && field_in[FIELD_W-1:FIELD_W-2] == 2'b00) |-> (res_d.carry == carry_in));

    assert_invalid_only_zero_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_d.valid |-> (mode_compact && field_in[FIELD_W-1:FIELD_W-2] == 2'b00 &&
                          field_in[BYTE_W+1:BYTE_W] != 2'b00 && field_in[BYTE_W-1:0] == '0));
endmodule

// File: tb/immx_expand_bench.sv
module immx_expand_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] field_in = '0;
    logic        mode_compact = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] imm_value;
    logic        carry_out;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    immx_expand #(.REG_OUT(1'b1)) u_immx_expand (
        .clk(clk), .rst_n(rst_n), .field_in(field_in), .mode_compact(mode_compact),
        .carry_in(carry_in), .imm_value(imm_value), .carry_out(carry_out), .valid(valid));

    function automatic logic [31:0] ror_ref(input logic [31:0] x, input int amt);
        logic [31:0] r = x;
        for (int i = 0; i < amt; i++) r = {r[0], r[31:1]};
        return r;
    endfunction

    // expected {valid, carry, value}
    function automatic logic [33:0] model(input logic [11:0] f, input logic m, input logic c);
        logic [31:0] v; logic cy; logic ok; logic [7:0] b;
        b = f[7:0]; ok = 1'b1;
        if (!m) begin
            v  = ror_ref({24'h0, b}, 2 * int'(f[11:8]));
            cy = (f[11:8] == 0) ? c : v[31];
        end else if (f[11:10] == 2'b00) begin
            case (f[9:8])
                2'b00: v = {24'h0, b};
                2'b01: v = {8'h0, b, 8'h0, b};
                2'b10: v = {b, 8'h0, b, 8'h0};
                default: v = {b, b, b, b};
            endcase
            cy = c;
            ok = !(f[9:8] != 2'b00 && b == 8'h0);
        end else begin
            v  = ror_ref({24'h0, 1'b1, f[6:0]}, int'(f[11:7]));
            cy = v[31];
        end
        return {ok, cy, v};
    endfunction

    function automatic string tag_of(input logic [11:0] f, input logic m);
        if (!m) return (f[11:8] == 0) ? "R2" : "R1";
        if (f[11:10] != 2'b00) return "R7/R8";
        if (f[9:8] != 2'b00 && f[7:0] == 0) return "R9";
        case (f[9:8])
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [11:0] f, input logic m, input logic c);
        logic [33:0] exp;
        @(negedge clk);
        field_in = f; mode_compact = m; carry_in = c;
        exp = model(f, m, c);
        @(negedge clk);  // one register stage, R10
        checks++;
        if ({valid, carry_out, imm_value} !== exp) begin
            errors++;
            $display("FAIL %s/R10 field=%03h mode=%0b cin=%0b got v=%0b c=%0b val=%08h exp v=%0b c=%0b val=%08h",
                     tag_of(f, m), f, m, c, valid, carry_out, imm_value, exp[33], exp[32], exp[31:0]);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        field_in = 12'hFFF; mode_compact = 1'b1; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        checks++;  // R10 reset state
        if ({valid, carry_out, imm_value} !== 34'h0) begin
            errors++;
            $display("FAIL R10 reset got %09h exp 000000000", {valid, carry_out, imm_value});
        end
        rst_n = 1'b1;
        // directed corners
        apply(12'h0FF, 1'b0, 1'b1);  // R2 zero rotate keeps carry
        apply(12'h0FF, 1'b0, 1'b0);  // R2
        apply(12'h1FF, 1'b0, 1'b0);  // R1 rotate by 2
        apply(12'hF01, 1'b0, 1'b1);  // R1 rotate by 30
        apply(12'h000, 1'b0, 1'b1);  // R1 zero value
        apply(12'h0AB, 1'b1, 1'b1);  // R3
        apply(12'h1AB, 1'b1, 1'b0);  // R4
        apply(12'h2AB, 1'b1, 1'b1);  // R5
        apply(12'h3AB, 1'b1, 1'b0);  // R6
        apply(12'h100, 1'b1, 1'b1);  // R9 invalid
        apply(12'h300, 1'b1, 1'b0);  // R9 invalid
        apply(12'h000, 1'b1, 1'b1);  // R9 zero-extend zero stays valid
        apply(12'h400, 1'b1, 1'b0);  // R7/R8 rotate by 8
        apply(12'hFFF, 1'b1, 1'b0);  // R7/R8 rotate by 31
        // random mix
        for (int i = 0; i < 400; i++) begin
            apply(12'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule